// File: doc/BRIEF.md
# Eight-Pin GPIO Port Controller with Peripheral Pin Takeover

This block controls an 8-pin general-purpose I/O port. Software sets, through a small register bus, which pins drive, the level each driving pin carries, whether a driving pin works push-pull or open-drain, and whether each pin may use its pull-up. For every pin the block produces the four pad controls: output enable, output level, pull-up enable and pull-down enable. Pad levels pass through a two-flop synchronizer, and the synchronized levels can be read back as a read-only register, including on pins that are driving.

Two serial peripherals can take pins from the port. When a synchronous serial unit is enabled, pins 4 and 5 carry its lines S0 and S1 as open-drain lines whose direction the unit chooses. When a UART is enabled, pin 6 carries its transmit line and pin 7 its receive line. The pull-up is switched on only where it can be useful: on a pin that is not driving, or on an open-drain pin that is released. While power-on reset is active, pin 1 is pulled down instead of up.

Top module: `gpio_port_ctl`

## Requirements
- R1: Register map (3-bit address): 0 = direction, 1 = output data, 2 = open-drain select, 3 = pull-up select, 4 = synchronized input (read-only), 5 to 7 read as 0. A write with reg_we high updates the addressed register at the next rising clock edge; reads are combinational.
- R2: After rst_n, direction, output data and open-drain select are all 0 and pull-up select is 0xFF.
- R3: A pin whose direction bit is 0, and that no peripheral has taken, has pad_oe low.
- R4: A direction bit of 1 with open-drain select 0 gives pad_oe high and pad_out equal to the output data bit.
- R5: A direction bit of 1 with open-drain select 1 gives pad_oe high and pad_out low when the data bit is 0, and pad_oe low when the data bit is 1.
- R6: pad_pu of a pin is high only when its pull-up select bit is 1 and the pin either does not drive or is open-drain holding a 1; a pin with pad_oe high never has pad_pu high.
- R7: While por_active is high, pin 1 has pad_pu low and pad_pd high. pad_pd is low on every other pin at all times, and on pin 1 whenever por_active is low.
- R8: The input register and the ser_s0_in, ser_s1_in and uart_rx outputs reflect the pad levels two clock edges after they change; writes to address 4 have no effect.
- R9: With ser_en high, pins 4 and 5 are open-drain lines: when ser_s0_oe (pin 4) or ser_s1_oe (pin 5) is high the pin drives ser_s0_out or ser_s1_out, otherwise pad_oe is low. Register direction, data and open-drain bits for these pins are ignored; their pull-up select bits still apply.
- R10: With uart_tx_en high, pin 6 drives uart_tx regardless of its direction and data bits, using its open-drain select bit. With uart_rx_en high, pin 7 is input-only and uart_rx carries its synchronized level; with uart_rx_en low, uart_rx is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low register reset |
| por_active | input | 1 | High while power-on reset is in progress |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output levels |
| pad_pu | output | 8 | Pad pull-up enables |
| pad_pd | output | 8 | Pad pull-down enables |
| ser_en | input | 1 | Synchronous serial unit takes pins 4 and 5 |
| ser_s0_oe | input | 1 | S0 line drives |
| ser_s0_out | input | 1 | S0 output level |
| ser_s0_in | output | 1 | Synchronized level of pin 4 |
| ser_s1_oe | input | 1 | S1 line drives |
| ser_s1_out | input | 1 | S1 output level |
| ser_s1_in | output | 1 | Synchronized level of pin 5 |
| uart_tx_en | input | 1 | UART takes pin 6 for transmit |
| uart_tx | input | 1 | UART transmit level |
| uart_rx_en | input | 1 | UART takes pin 7 for receive |
| uart_rx | output | 1 | Synchronized level of pin 7, 1 when disabled |

## Verification
The assertions assume pad_in is a clean two-state value sampled at clock edges, that por_active is only high around reset, and that the peripheral enables and line controls are ordinary levels rather than glitching strobes. The bench changes every input half a cycle away from the rising edge, keeps por_active low once the directed reset checks are done, and draws registers, peripheral enables, line controls and pad levels from a seeded generator so that override and non-override combinations on every pin are mixed with the directed latency and reset cases.

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl #(
  parameter int W      = 8,
  parameter int PD_PIN = 1,
  parameter int S0_PIN = 4,
  parameter int S1_PIN = 5,
  parameter int TX_PIN = 6,
  parameter int RX_PIN = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         por_active,
  input  logic         reg_we,
  input  logic [2:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu,
  output logic [W-1:0] pad_pd,
  input  logic         ser_en,
  input  logic         ser_s0_oe,
  input  logic         ser_s0_out,
  output logic         ser_s0_in,
  input  logic         ser_s1_oe,
  input  logic         ser_s1_out,
  output logic         ser_s1_in,
  input  logic         uart_tx_en,
  input  logic         uart_tx,
  input  logic         uart_rx_en,
  output logic         uart_rx
);

  localparam logic [2:0] A_DIR = 3'd0;
  localparam logic [2:0] A_DAT = 3'd1;
  localparam logic [2:0] A_OD  = 3'd2;
  localparam logic [2:0] A_PUS = 3'd3;
  localparam logic [2:0] A_IN  = 3'd4;

  logic [W-1:0] dir_q, dat_q, od_q, pus_q;
  logic [W-1:0] sync1_q, sync2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
      od_q  <= '0;
      pus_q <= '1;
    end else if (reg_we) begin
      case (reg_addr)
        A_DIR:   dir_q <= reg_wdata;
        A_DAT:   dat_q <= reg_wdata;
        A_OD:    od_q  <= reg_wdata;
        A_PUS:   pus_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    case (reg_addr)
      A_DIR:   reg_rdata = dir_q;
      A_DAT:   reg_rdata = dat_q;
      A_OD:    reg_rdata = od_q;
      A_PUS:   reg_rdata = pus_q;
      A_IN:    reg_rdata = sync2_q;
      default: reg_rdata = '0;
    endcase
  end

  assign ser_s0_in = sync2_q[S0_PIN];
  assign ser_s1_in = sync2_q[S1_PIN];
  assign uart_rx   = uart_rx_en ? sync2_q[RX_PIN] : 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic drv, odm, val;
    always_comb begin
      drv = dir_q[i];
      odm = od_q[i];
      val = dat_q[i];
      if (i == S0_PIN && ser_en) begin
        drv = ser_s0_oe;
        odm = 1'b1;
        val = ser_s0_out;
      end else if (i == S1_PIN && ser_en) begin
        drv = ser_s1_oe;
        odm = 1'b1;
        val = ser_s1_out;
      end else if (i == TX_PIN && uart_tx_en) begin
        drv = 1'b1;
        val = uart_tx;
      end else if (i == RX_PIN && uart_rx_en) begin
        drv = 1'b0;
      end
    end
    logic por_here;
    assign por_here   = (i == PD_PIN) ? por_active : 1'b0;
    assign pad_oe[i]  = drv & (~odm | ~val);
    assign pad_out[i] = val & ~odm;
    assign pad_pu[i]  = pus_q[i] & (~drv | (odm & val)) & ~por_here;
    assign pad_pd[i]  = por_here;
  end

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  // R6
  pu_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pu) == '0);

  // R7
  por_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_active |-> (!pad_pu[PD_PIN] && pad_pd[PD_PIN]));

  // R7
  pd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !por_active |-> (pad_pd == '0));

  // R8
  sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (sync2_q == $past(pad_in, 2)));

  // R9
  ser_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && !ser_s0_oe) |-> !pad_oe[S0_PIN]);

  // R9
  ser_od_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |-> (!pad_out[S0_PIN] && !pad_out[S1_PIN]));

  // R10
  rx_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uart_rx_en |-> !pad_oe[RX_PIN]);

  // R1
  wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_DIR) |=> (dir_q == $past(reg_wdata)));

endmodule

// File: tb/gpio_port_ctl_tb.sv
module gpio_port_ctl_tb;
  logic clk = 0, rst_n = 0, por_active = 1;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, pad_in = 0;
  logic [7:0] pad_oe, pad_out, pad_pu, pad_pd;
  logic ser_en = 0, ser_s0_oe = 0, ser_s0_out = 0, ser_s0_in;
  logic ser_s1_oe = 0, ser_s1_out = 0, ser_s1_in;
  logic uart_tx_en = 0, uart_tx = 0, uart_rx_en = 0, uart_rx;
  int checks = 0, failures = 0;
  logic [7:0] m_dir, m_dat, m_od, m_pus;

  always #10 clk = ~clk;

  gpio_port_ctl u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [7:0] d, o, od, pu, input logic por);
    logic [7:0] oe, out, pup, pdn;
    for (int i = 0; i < 8; i++) begin
      logic drv, opn, v;
      drv = d[i]; opn = od[i]; v = o[i];
      if (ser_en && i == 4) begin drv = ser_s0_oe; opn = 1; v = ser_s0_out; end
      else if (ser_en && i == 5) begin drv = ser_s1_oe; opn = 1; v = ser_s1_out; end
      else if (uart_tx_en && i == 6) begin drv = 1; v = uart_tx; end
      else if (uart_rx_en && i == 7) drv = 0;
      oe[i]  = drv && (!opn || !v);
      out[i] = drv && !opn ? v : 1'b0;
      pup[i] = pu[i] && (!drv || (opn && v)) && !(i == 1 && por);
      pdn[i] = (i == 1) && por;
    end
    return {oe, out & oe, pup, pdn};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
    reg_addr = a; #1;
    chk(req, {24'd0, reg_rdata}, {24'd0, exp});
  endtask

  task automatic chk_pads(input string req);
    #1;
    chk(req, {pad_oe, pad_out & pad_oe, pad_pu, pad_pd}, model(m_dir, m_dat, m_od, m_pus, por_active));
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_dir = 0; m_dat = 0; m_od = 0; m_pus = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset values
    rd("R2 dir", 3'd0, 8'h00);
    rd("R2 dat", 3'd1, 8'h00);
    rd("R2 od", 3'd2, 8'h00);
    rd("R2 pus", 3'd3, 8'hFF);
    // R7 during power-on reset
    chk("R7 pd during por", {24'd0, pad_pd}, 32'h02);
    chk("R7 pu during por", {24'd0, pad_pu}, 32'hFD);
    chk("R3 no drive after reset", {24'd0, pad_oe}, 32'h0);
    por_active = 0; #1;
    chk("R7 pd after por", {24'd0, pad_pd}, 32'h0);
    chk("R6 pu after por", {24'd0, pad_pu}, 32'hFF);

    // R1 unused addresses and write to input ignored (R8)
    rd("R1 addr5", 3'd5, 8'h00);
    rd("R1 addr7", 3'd7, 8'h00);
    wr(3'd4, 8'h5A);
    rd("R8 in ignores write", 3'd4, 8'h00);

    // R8 two-edge latency
    @(negedge clk); pad_in = 8'hB5;
    @(negedge clk); rd("R8 in after 1 edge", 3'd4, 8'h00);
    @(negedge clk); rd("R8 in after 2 edges", 3'd4, 8'hB5);
    chk("R8 ser_s0_in", {31'd0, ser_s0_in}, 32'd1);
    chk("R8 ser_s1_in", {31'd0, ser_s1_in}, 32'd1);
    chk("R10 uart_rx idle", {31'd0, uart_rx}, 32'd1);
    pad_in = 8'h35; uart_rx_en = 1;
    @(negedge clk); @(negedge clk); #1;
    chk("R10 uart_rx follows pin7", {31'd0, uart_rx}, 32'd0);
    uart_rx_en = 0;

    // R4 push-pull, R5 open-drain directed
    wr(3'd0, 8'hFF); m_dir = 8'hFF;
    wr(3'd1, 8'hA5); m_dat = 8'hA5;
    chk_pads("R4 push-pull all out");
    chk("R4 pad_out", {24'd0, pad_out}, 32'hA5);
    wr(3'd2, 8'hFF); m_od = 8'hFF;
    chk("R5 open-drain oe", {24'd0, pad_oe}, 32'h5A);
    chk("R6 open-drain released pull-up", {24'd0, pad_pu}, 32'hA5);

    // R9 serial takeover ignores registers
    ser_en = 1; ser_s0_oe = 1; ser_s0_out = 0; ser_s1_oe = 0; ser_s1_out = 0;
    wr(3'd2, 8'h00); m_od = 8'h00;
    wr(3'd1, 8'hFF); m_dat = 8'hFF;
    #1;
    chk("R9 s0 drives low", {30'd0, pad_oe[5:4]}, 32'b01);
    chk("R9 s0 out low", {31'd0, pad_out[4]}, 32'd0);
    chk_pads("R9 serial pads");
    ser_en = 0; ser_s0_oe = 0;

    // R10 tx takeover
    wr(3'd0, 8'h00); m_dir = 8'h00;
    uart_tx_en = 1; uart_tx = 1; #1;
    chk("R10 tx drives", {30'd0, pad_oe[6], pad_out[6]}, 32'b11);
    uart_tx_en = 0;

    // random phase, R1..R10
    for (int n = 0; n < 400; n++) begin
      logic [7:0] v;
      v = 8'($urandom); wr(3'd0, v); m_dir = v;
      v = 8'($urandom); wr(3'd1, v); m_dat = v;
      v = 8'($urandom); wr(3'd2, v); m_od = v;
      v = 8'($urandom); wr(3'd3, v); m_pus = v;
      @(negedge clk);
      ser_en = 1'($urandom); ser_s0_oe = 1'($urandom); ser_s0_out = 1'($urandom);
      ser_s1_oe = 1'($urandom); ser_s1_out = 1'($urandom);
      uart_tx_en = 1'($urandom); uart_tx = 1'($urandom); uart_rx_en = 1'($urandom);
      pad_in = 8'($urandom);
      chk_pads("R3 R4 R5 R6 R9 R10 random pads");
      rd("R1 random dir readback", 3'd0, m_dir);
      rd("R1 random od readback", 3'd2, m_od);
      rd("R1 random pus readback", 3'd3, m_pus);
      @(negedge clk); @(negedge clk);
      rd("R8 random input", 3'd4, pad_in);
      chk("R10 random rx", {31'd0, uart_rx}, {31'd0, uart_rx_en ? pad_in[7] : 1'b1});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule